// File: doc/BRIEF.md
# Clock Reconfiguration Bypass Sequencer

This block holds the settings of a processor clock generator and changes them safely. Software offers a new configuration on a valid/ready port. The configuration holds a 6-bit feedback multiplier field, an input pre-divide bit, a 2-bit post-divide code and a post-divide enable. The block first moves the core clock onto the raw reference input by raising a bypass select. It then waits a settle interval and copies the shadowed settings to the active control outputs. After a second interval of the same length, which gives the loop time to lock, it drops bypass. A short stabilisation interval follows, and only then does it report completion. The analog loop itself is not part of the block.

The resulting core frequency is reference × 2 × M / (N × D). D is 2 when the pre-divide bit is set and 1 when it is clear. The block presents M and N as decoded values, so downstream logic does not need to interpret the codes.

Back-pressure: `cfg_ready` is low for the whole sequence. A request offered while ready is low is not held and is not queued. It is dropped, and `cfg_err` pulses for one cycle. A separate register carries one clock-off bit per peripheral. It can be written at any time.

Top module: `pll_reconfig_seq`

## Requirements
- R1: After reset, `busy`, `bypass_sel`, `done` and `cfg_err` are 0, `cfg_ready` is 1, `periph_clk_off` is all zeros, and the active outputs hold the reset configuration: multiplier 16, pre-divide 0, post-divide disabled (`act_post_n` = 1).
- R2: A request is accepted on a rising edge where `cfg_valid` and `cfg_ready` are both 1. From the next cycle on, `busy` and `bypass_sel` are 1.
- R3: The active outputs stay unchanged for SETTLE cycles after the accepting edge. They take the new settings on edge SETTLE after it, and they never change while `bypass_sel` is 0.
- R4: `bypass_sel` stays 1 until edge 2·SETTLE after the accepting edge and is 0 after that edge.
- R5: `busy` stays 1 until edge 2·SETTLE+STABLE after the accepting edge. It is 0 after that edge, and `done` is 1 for exactly that one following cycle.
- R6: A request offered while `cfg_ready` is 0 is dropped. `cfg_err` is 1 in the cycle after that edge, and the sequence in progress completes with its own settings.
- R7: `act_mult_val` equals the multiplier field, except that field value 0 gives 64.
- R8: When the post-divide enable is 1, post-divide codes 0, 1, 2 and 3 give `act_post_n` = 2, 4, 8 and 16. When the enable is 0, `act_post_n` is 1.
- R9: A rising edge with `periph_wr` = 1 loads `periph_wdata` into `periph_clk_off`, visible from the next cycle. A bit of 1 stops that peripheral's clock.
- R10: `cfg_ready` is the inverse of `busy` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration request valid |
| cfg_ready | output | 1 | Request can be accepted (not busy) |
| cfg_mult | input | 6 | Multiplier field (0 means 64) |
| cfg_prediv | input | 1 | Input pre-divide by 2 when 1 |
| cfg_post_code | input | 2 | Post-divide code |
| cfg_post_en | input | 1 | Post-divide enable |
| cfg_err | output | 1 | Pulse: request dropped while busy |
| periph_wr | input | 1 | Peripheral clock-off register write |
| periph_wdata | input | NUM_PERIPH | Write data, one bit per peripheral |
| periph_clk_off | output | NUM_PERIPH | 1 = peripheral clock stopped |
| bypass_sel | output | 1 | 1 = core clock from raw reference |
| act_mult_val | output | 7 | Active multiplier value M (1..64) |
| act_prediv | output | 1 | Active pre-divide bit |
| act_post_en | output | 1 | Active post-divide enable |
| act_post_n | output | 5 | Active post-divide value N (1 when disabled) |
| busy | output | 1 | Reconfiguration sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Take E as the accepting edge. `busy`, `bypass_sel` and `cfg_err` respond one edge after their cause. The active settings move on edge E+SETTLE, bypass falls on edge E+2·SETTLE, and `busy` falls with `done` rising on edge E+2·SETTLE+STABLE. The bench drives inputs on falling edges and counts falling edges from E. For each of these results it samples once just before the edge on which the value is due and once just after, so a result that is one cycle early or one cycle late is caught. A monitor compares the active settings against a queue of expected configurations each time `done` is seen.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int unsigned MULT_W = 6;
  localparam int unsigned POST_W = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_SETTLE, PH_LOCK, PH_STAB} phase_t;

  typedef struct packed {
    logic [MULT_W-1:0] mult;
    logic              prediv;
    logic [POST_W-1:0] post_code;
    logic              post_en;
  } clk_cfg_t;

  // Multiplier field to value: zero encodes the largest value.
  function automatic logic [MULT_W:0] mult_value(input logic [MULT_W-1:0] f);
    return (f == '0) ? (MULT_W+1)'(1 << MULT_W) : {1'b0, f};
  endfunction

  // Post-divide code to divisor: 2 << code when enabled, 1 otherwise.
  function automatic logic [(1<<POST_W):0] post_value(input logic [POST_W-1:0] code,
                                                       input logic en);
    return en ? ((1 << POST_W) + 1)'(2 << code) : ((1 << POST_W) + 1)'(1);
  endfunction
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (cnt != limit) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == limit);

  // R4/R5: the interval counter never runs past its current limit
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int unsigned SETTLE   = 4096,
  parameter int unsigned STABLE   = 15,
  parameter int unsigned RST_MULT = 16,
  localparam int unsigned MAXC    = (SETTLE > STABLE) ? SETTLE : STABLE,
  localparam int unsigned CNT_W   = $clog2(MAXC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  clk_cfg_t         cfg_in,
  output logic             cfg_ready,
  output logic             cfg_err,
  input  logic             expired,
  output logic             restart,
  output logic [CNT_W-1:0] limit,
  output logic             bypass_sel,
  output clk_cfg_t         act,
  output logic             busy,
  output logic             done
);
  localparam clk_cfg_t RST_CFG = '{mult: MULT_W'(RST_MULT), prediv: 1'b0,
                                   post_code: '0, post_en: 1'b0};

  phase_t   phase;
  clk_cfg_t shadow;
  logic     accept;

  assign busy      = (phase != PH_IDLE);
  assign cfg_ready = !busy;
  assign accept    = cfg_valid && !busy;
  assign restart   = !busy || expired;
  assign limit     = (phase == PH_STAB) ? CNT_W'(STABLE - 1) : CNT_W'(SETTLE - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      bypass_sel <= 1'b0;
      shadow     <= RST_CFG;
      act        <= RST_CFG;
      cfg_err    <= 1'b0;
      done       <= 1'b0;
    end else begin
      cfg_err <= cfg_valid && busy;
      done    <= 1'b0;
      unique case (phase)
        PH_IDLE: if (accept) begin
          shadow     <= cfg_in;
          bypass_sel <= 1'b1;
          phase      <= PH_SETTLE;
        end
        PH_SETTLE: if (expired) begin
          act   <= shadow;
          phase <= PH_LOCK;
        end
        PH_LOCK: if (expired) begin
          bypass_sel <= 1'b0;
          phase      <= PH_STAB;
        end
        PH_STAB: if (expired) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_accept_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |=> busy && bypass_sel);
  assert_apply_in_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_sel |=> $stable(act));
  assert_bypass_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bypass_sel);
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_drop_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_err);
  assert_no_false_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> !cfg_err);
endmodule

// File: rtl/pll_periph_gate.sv
module pll_periph_gate #(
  parameter int unsigned NUM_PERIPH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [NUM_PERIPH-1:0] wdata,
  output logic [NUM_PERIPH-1:0] clk_off
);
  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)  clk_off[i] <= 1'b0;
      else if (wr) clk_off[i] <= wdata[i];
    end
  end

  assert_periph_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> clk_off == $past(wdata));
  assert_periph_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(clk_off));
endmodule

// File: rtl/pll_reconfig_seq.sv
module pll_reconfig_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned SETTLE     = 4096,
  parameter int unsigned STABLE     = 15,
  parameter int unsigned RST_MULT   = 16,
  parameter int unsigned NUM_PERIPH = 8,
  localparam int unsigned MAXC      = (SETTLE > STABLE) ? SETTLE : STABLE,
  localparam int unsigned CNT_W     = $clog2(MAXC + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_valid,
  output logic                  cfg_ready,
  input  logic [5:0]            cfg_mult,
  input  logic                  cfg_prediv,
  input  logic [1:0]            cfg_post_code,
  input  logic                  cfg_post_en,
  output logic                  cfg_err,
  input  logic                  periph_wr,
  input  logic [NUM_PERIPH-1:0] periph_wdata,
  output logic [NUM_PERIPH-1:0] periph_clk_off,
  output logic                  bypass_sel,
  output logic [6:0]            act_mult_val,
  output logic                  act_prediv,
  output logic                  act_post_en,
  output logic [4:0]            act_post_n,
  output logic                  busy,
  output logic                  done
);
  clk_cfg_t         cfg_in, act;
  logic             restart, expired;
  logic [CNT_W-1:0] limit;

  assign cfg_in = '{mult: cfg_mult, prediv: cfg_prediv,
                    post_code: cfg_post_code, post_en: cfg_post_en};

  pll_seq_ctrl #(.SETTLE(SETTLE), .STABLE(STABLE), .RST_MULT(RST_MULT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_in(cfg_in),
    .cfg_ready(cfg_ready), .cfg_err(cfg_err), .expired(expired),
    .restart(restart), .limit(limit), .bypass_sel(bypass_sel), .act(act),
    .busy(busy), .done(done));

  pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .limit(limit), .expired(expired));

  pll_periph_gate #(.NUM_PERIPH(NUM_PERIPH)) u_periph (
    .clk(clk), .rst_n(rst_n), .wr(periph_wr), .wdata(periph_wdata),
    .clk_off(periph_clk_off));

  assign act_mult_val = mult_value(act.mult);
  assign act_prediv   = act.prediv;
  assign act_post_en  = act.post_en;
  assign act_post_n   = post_value(act.post_code, act.post_en);

  assert_ready_inv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready != busy);
  assert_mult_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_mult_val != 7'd0 && act_mult_val <= 7'd64);
  assert_post_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_post_n) && act_post_n != 5'd0);
endmodule

// File: tb/pll_reconfig_seq_bench.sv
module pll_reconfig_seq_bench;
  localparam int SETTLE = 4096;
  localparam int STABLE = 15;
  localparam int NP     = 8;

  typedef struct {
    int mult; int prediv; int post_en; int post_n;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0, cfg_prediv = 0, cfg_post_en = 0, periph_wr = 0;
  logic [5:0] cfg_mult = '0;
  logic [1:0] cfg_post_code = '0;
  logic [NP-1:0] periph_wdata = '0;
  logic cfg_ready, cfg_err, bypass_sel, act_prediv, act_post_en, busy, done;
  logic [NP-1:0] periph_clk_off;
  logic [6:0] act_mult_val;
  logic [4:0] act_post_n;

  int checks = 0, fails = 0;
  bit finished = 0;
  exp_t exp_q[$];
  exp_t cur;

  always #2 clk = ~clk;

  pll_reconfig_seq u_pll_reconfig_seq (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_mult(cfg_mult), .cfg_prediv(cfg_prediv), .cfg_post_code(cfg_post_code),
    .cfg_post_en(cfg_post_en), .cfg_err(cfg_err), .periph_wr(periph_wr),
    .periph_wdata(periph_wdata), .periph_clk_off(periph_clk_off),
    .bypass_sel(bypass_sel), .act_mult_val(act_mult_val), .act_prediv(act_prediv),
    .act_post_en(act_post_en), .act_post_n(act_post_n), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic exp_t model(input int m, input int pd, input int code, input int en);
    exp_t e;
    e.mult = (m == 0) ? 64 : m;
    e.prediv = pd;
    e.post_en = en;
    e.post_n = en ? (2 << code) : 1;
    return e;
  endfunction

  task automatic chk_act(input exp_t e, input string req);
    chk(act_mult_val == e.mult, req, act_mult_val, e.mult);
    chk(act_prediv == e.prediv, req, act_prediv, e.prediv);
    chk(act_post_en == e.post_en, req, act_post_en, e.post_en);
    chk(act_post_n == e.post_n, req, act_post_n, e.post_n);
  endtask

  // Monitor: compare active settings at each completion pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected done", 1, 0);
      else chk_act(exp_q.pop_front(), "R3/R7/R8 scoreboard");
    end
  end

  // Driver: one full reconfiguration with cycle-exact checks.
  task automatic run_cfg(input int m, input int pd, input int code, input int en,
                         input bit probe);
    exp_t e = model(m, pd, code, en);
    exp_q.push_back(e);
    chk(cfg_ready == 1, "R10 ready idle", cfg_ready, 1);
    cfg_valid = 1; cfg_mult = 6'(m); cfg_prediv = 1'(pd);
    cfg_post_code = 2'(code); cfg_post_en = 1'(en);
    step(1);                                   // after edge E
    cfg_valid = 0;
    chk(busy == 1, "R2 busy", busy, 1);
    chk(bypass_sel == 1, "R2 bypass", bypass_sel, 1);
    chk(cfg_ready == 0, "R10 ready busy", cfg_ready, 0);
    if (probe) begin
      cfg_valid = 1; cfg_mult = 6'd5; cfg_post_code = 2'd0; cfg_post_en = 1;
      step(1);                                 // after E+1
      cfg_valid = 0;
      chk(cfg_err == 1, "R6 err pulse", cfg_err, 1);
      step(1);                                 // after E+2
      chk(cfg_err == 0, "R6 err ends", cfg_err, 0);
      step(SETTLE - 3);
    end else step(SETTLE - 1);                 // after E+SETTLE-1
    chk_act(cur, "R3 held before apply");
    step(1);                                   // after E+SETTLE
    chk_act(e, "R3 applied");
    chk(bypass_sel == 1, "R3 applied in bypass", bypass_sel, 1);
    step(SETTLE - 1);                          // after E+2S-1
    chk(bypass_sel == 1, "R4 bypass held", bypass_sel, 1);
    step(1);                                   // after E+2S
    chk(bypass_sel == 0, "R4 bypass off", bypass_sel, 0);
    chk(busy == 1, "R5 still busy", busy, 1);
    step(STABLE - 1);                          // after E+2S+STABLE-1
    chk(busy == 1, "R5 busy end", busy, 1);
    chk(done == 0, "R5 no early done", done, 0);
    step(1);                                   // after E+2S+STABLE
    chk(busy == 0, "R5 idle", busy, 0);
    chk(done == 1, "R5 done", done, 1);
    step(1);
    chk(done == 0, "R5 done one cycle", done, 0);
    cur = e;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cur = model(16, 0, 0, 0);
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(bypass_sel == 0, "R1 bypass", bypass_sel, 0);
    chk(cfg_ready == 1, "R1 ready", cfg_ready, 1);
    chk(cfg_err == 0, "R1 err", cfg_err, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(periph_clk_off == 0, "R1 periph", periph_clk_off, 0);
    chk_act(cur, "R1 active");

    // R9 peripheral register
    periph_wr = 1; periph_wdata = 8'hA5;
    step(1);
    periph_wr = 0;
    chk(periph_clk_off == 8'hA5, "R9 load", periph_clk_off, 8'hA5);
    periph_wdata = 8'h00;
    step(2);
    chk(periph_clk_off == 8'hA5, "R9 hold", periph_clk_off, 8'hA5);

    run_cfg(20, 1, 2, 1, 1);   // R6 probe: dropped write must not land
    run_cfg(0, 0, 3, 1, 0);    // R7 zero -> 64, R8 code 3 -> 16
    run_cfg(63, 0, 1, 0, 0);   // R8 disabled -> 1
    run_cfg(1, 1, 0, 1, 0);    // R8 code 0 -> 2
    chk(exp_q.size() == 0, "R5 all completions seen", exp_q.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule